// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second operand of a RISC integer datapath. It is purely combinational and has no clock. It takes a data word, a two-bit shift kind, an eight-bit shift count and a flag that says where the count came from: a register or an immediate field of the instruction. From these it produces the shifted word and the carry the shifter generates. That carry is what a logical instruction writes into the flag register.

Counts of zero and counts of the word width or more follow fixed rules. They are not left to the natural behaviour of a hardware shifter. An immediate count of zero is read either as a full-width shift or as a one-bit rotate through the carry, depending on the kind. Every count above the word width gives a defined result and a defined carry.

A second operand form bypasses the shifter path. In this form a small constant is zero-extended and rotated right by twice a short rotate field. The carry flag then passes through untouched.

Top module: `opnd_shifter`

## Requirements
- R1: With the count taken from a register (`cnt_is_reg_i`=1) and equal to 0, `shf_o` equals `word_i` and `cy_o` equals `cy_i`, whatever the kind.
- R2: Kind 00 (logical left): a count of 0 passes the word with `cy_o`=`cy_i`. A count n of 1..31 shifts left with `cy_o` = bit 32-n of the input. A count of 32 gives 0 with `cy_o` = bit 0. A count of 33 or more gives 0 with `cy_o`=0.
- R3: Kind 01 (logical right): an immediate count of 0 acts as 32, giving 0 with `cy_o` = bit 31. A count n of 1..31 shifts right with `cy_o` = bit n-1. A count of 32 gives 0 with bit 31 as carry. A count of 33 or more gives 0 with `cy_o`=0.
- R4: Kind 10 (arithmetic right): an immediate count of 0, or any count of 32 or more, copies bit 31 into every bit and sets `cy_o` = bit 31. A count n of 1..31 shifts right with sign fill and `cy_o` = bit n-1.
- R5: Kind 11 (rotate right) with an immediate count of 0 rotates right one bit through the carry: `cy_i` enters bit 31 and input bit 0 becomes `cy_o`.
- R6: Kind 11 with a nonzero count n uses n mod 32. If that remainder is 0, the word passes with `cy_o` = bit 31. Otherwise the word is rotated right by the remainder and `cy_o` = bit (remainder-1).
- R7: With `imm_sel_i`=1, `shf_o` is the 8-bit `imm_val_i` zero-extended and rotated right by 2×`imm_rot_i`, and `cy_o`=`cy_i`. The word, kind and count are ignored in this form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| cnt_i | input | 8 | Shift count |
| cnt_is_reg_i | input | 1 | 1 when the count came from a register |
| imm_sel_i | input | 1 | Selects the rotated-constant form |
| imm_val_i | input | 8 | Constant for the rotated-constant form |
| imm_rot_i | input | 4 | Half of the rotate count for the constant |
| cy_i | input | 1 | Current carry flag |
| shf_o | output | 32 | Shifted operand |
| cy_o | output | 1 | Shifter carry-out |

## Verification
The block holds no state. A wrong selection therefore shows at once, in the same evaluation, as a wrong word or a wrong carry for the input vector that exercises it. Most faults hide in the edge counts: 0, 31, 32, 33 and multiples of 32. For that reason every kind is driven with every count from 0 to 255, both as an immediate count and as a register count, each on a random word and a random carry. Directed vectors add a sign-filled arithmetic shift, a rotate through the carry, and a constant rotated across the word boundary.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W  = 32,
  parameter int CW = 8,
  parameter int IW = 8,
  parameter int RW = 4
) (
  input  logic [W-1:0]  word_i,
  input  logic [1:0]    kind_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_is_reg_i,
  input  logic          imm_sel_i,
  input  logic [IW-1:0] imm_val_i,
  input  logic [RW-1:0] imm_rot_i,
  input  logic          cy_i,
  output logic [W-1:0]  shf_o,
  output logic          cy_o
);
  localparam int SW = $clog2(W);

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input logic [SW-1:0] s);
    logic [2*W-1:0] d;
    d = {v, v} >> s;
    return d[W-1:0];
  endfunction

  logic [W-1:0]  res;
  logic          cy;
  logic [31:0]   n;
  logic [SW-1:0] k;

  always_comb begin
    n   = 32'(cnt_i);
    k   = cnt_i[SW-1:0];
    res = word_i;
    cy  = cy_i;
    if (imm_sel_i) begin
      res = rotr(W'(imm_val_i), SW'({imm_rot_i, 1'b0}));
    end else if (!(cnt_is_reg_i && n == 0)) begin
      case (kind_i)
        2'b00: begin
          if (n == 0) begin
            res = word_i;
          end else if (n < W) begin
            res = word_i << k;
            cy  = word_i[SW'(W - n)];
          end else if (n == W) begin
            res = '0;
            cy  = word_i[0];
          end else begin
            res = '0;
            cy  = 1'b0;
          end
        end
        2'b01: begin
          if (n == 0 || n == W) begin
            res = '0;
            cy  = word_i[W-1];
          end else if (n < W) begin
            res = word_i >> k;
            cy  = word_i[k - 1'b1];
          end else begin
            res = '0;
            cy  = 1'b0;
          end
        end
        2'b10: begin
          if (n == 0 || n >= W) begin
            res = {W{word_i[W-1]}};
            cy  = word_i[W-1];
          end else begin
            res = W'($signed(word_i) >>> k);
            cy  = word_i[k - 1'b1];
          end
        end
        default: begin
          if (n == 0) begin
            res = {cy_i, word_i[W-1:1]};
            cy  = word_i[0];
          end else if (k == 0) begin
            res = word_i;
            cy  = word_i[W-1];
          end else begin
            res = rotr(word_i, k);
            cy  = word_i[k - 1'b1];
          end
        end
      endcase
    end

    if (!imm_sel_i && cnt_is_reg_i && n == 0)
      assert_regzero_pass_R1: assert (res == word_i && cy == cy_i);
    if (!imm_sel_i && kind_i == 2'b00 && n > W)
      assert_lsl_over_R2: assert (res == '0 && !cy);
    if (!imm_sel_i && kind_i == 2'b01 && n > W)
      assert_lsr_over_R3: assert (res == '0 && !cy);
    if (!imm_sel_i && kind_i == 2'b10 && n != 0)
      assert_asr_sign_R4: assert (res[W-1] == word_i[W-1]);
    if (!imm_sel_i && !cnt_is_reg_i && kind_i == 2'b11 && n == 0)
      assert_rrx_R5: assert (res[W-1] == cy_i && cy == word_i[0]);
    if (!imm_sel_i && kind_i == 2'b11 && n != 0)
      assert_ror_ones_R6: assert ($countones(res) == $countones(word_i));
    if (imm_sel_i)
      assert_imm_ones_R7: assert ($countones(res) == $countones(imm_val_i) && cy == cy_i);
  end

  assign shf_o = res;
  assign cy_o  = cy;
endmodule

// File: tb/sim_opnd_shifter.sv
module sim_opnd_shifter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] word;
  logic [1:0]  kind;
  logic [7:0]  cnt;
  logic        is_reg, imm_sel, cyin;
  logic [7:0]  ival;
  logic [3:0]  irot;
  logic [31:0] shf;
  logic        cyo;

  int total = 0;
  int bad   = 0;

  opnd_shifter u0 (
    .word_i(word), .kind_i(kind), .cnt_i(cnt), .cnt_is_reg_i(is_reg),
    .imm_sel_i(imm_sel), .imm_val_i(ival), .imm_rot_i(irot), .cy_i(cyin),
    .shf_o(shf), .cy_o(cyo)
  );

  function automatic logic [32:0] model(input logic [31:0] v, input logic [1:0] t,
      input int c, input logic rg, input logic im, input logic [7:0] iv,
      input logic [3:0] ir, input logic ci);
    logic [31:0] x;
    logic cc;
    int m;
    x = v;
    cc = ci;
    if (im) begin
      x = {24'h0, iv};
      for (int i = 0; i < 2 * int'(ir); i++) x = {x[0], x[31:1]};
      return {cc, x};
    end
    if (rg && c == 0) return {ci, v};
    case (t)
      2'b00: for (int i = 0; i < c; i++) begin cc = x[31]; x = {x[30:0], 1'b0}; end
      2'b01: begin
        m = (c == 0) ? 32 : c;
        for (int i = 0; i < m; i++) begin cc = x[0]; x = {1'b0, x[31:1]}; end
      end
      2'b10: begin
        m = (c == 0) ? 32 : c;
        for (int i = 0; i < m; i++) begin cc = x[0]; x = {x[31], x[31:1]}; end
      end
      default: begin
        if (c == 0) begin
          cc = x[0]; x = {ci, x[31:1]};
        end else if (c % 32 == 0) begin
          cc = x[31];
        end else begin
          for (int i = 0; i < c % 32; i++) begin cc = x[0]; x = {x[0], x[31:1]}; end
        end
      end
    endcase
    return {cc, x};
  endfunction

  function automatic string tag_of();
    if (imm_sel) return "R7";
    if (is_reg && cnt == 0) return "R1";
    case (kind)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return (cnt == 0) ? "R5" : "R6";
    endcase
  endfunction

  task automatic apply(input logic [31:0] v, input logic [1:0] t, input logic [7:0] c,
      input logic rg, input logic im, input logic [7:0] iv, input logic [3:0] ir,
      input logic ci);
    logic [32:0] exp;
    @(negedge clk);
    word = v; kind = t; cnt = c; is_reg = rg; imm_sel = im; ival = iv; irot = ir; cyin = ci;
    #1;
    exp = model(v, t, int'(c), rg, im, iv, ir, ci);
    total++;
    if ({cyo, shf} !== exp) begin
      bad++;
      $display("FAIL %s kind=%0d cnt=%0d reg=%0b imm=%0b: got cy=%0b val=%08h exp cy=%0b val=%08h",
               tag_of(), t, c, rg, im, cyo, shf, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    word = '0; kind = '0; cnt = '0; is_reg = 1'b0; imm_sel = 1'b0;
    ival = '0; irot = '0; cyin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // quiet state: all-zero inputs give zero word, zero carry (R2)
    apply(32'h0, 2'b00, 8'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0);
    // directed corners
    apply(32'h0000_0001, 2'b00, 8'd32, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0); // R2 count 32
    apply(32'hFFFF_FFFF, 2'b00, 8'd33, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1); // R2 over
    apply(32'h8000_0000, 2'b01, 8'd0,  1'b0, 1'b0, 8'h0, 4'h0, 1'b0); // R3 imm zero
    apply(32'h8000_0001, 2'b10, 8'd200,1'b1, 1'b0, 8'h0, 4'h0, 1'b0); // R4 large
    apply(32'h0000_0001, 2'b11, 8'd0,  1'b0, 1'b0, 8'h0, 4'h0, 1'b1); // R5 rrx
    apply(32'h8000_0000, 2'b11, 8'd64, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0); // R6 multiple of 32
    apply(32'h1234_5678, 2'b10, 8'd0,  1'b1, 1'b0, 8'h0, 4'h0, 1'b1); // R1 reg zero
    apply(32'hDEAD_BEEF, 2'b11, 8'd9,  1'b0, 1'b1, 8'hC3, 4'h1, 1'b1); // R7 wraps
    // sweep every kind, count and source
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 256; c++)
        for (int r = 0; r < 2; r++)
          apply($urandom, 2'(t), 8'(c), 1'(r), 1'b0, 8'($urandom), 4'($urandom), 1'($urandom));
    // rotated constants (R7)
    for (int i = 0; i < 400; i++)
      apply($urandom, 2'($urandom), 8'($urandom), 1'($urandom), 1'b1,
            8'($urandom), 4'($urandom), 1'($urandom));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule